// File: doc/BRIEF.md
# Double-Sided Uniform-Sampling PWM Modulator

This block turns a stream of 6-bit signed words into two-level pulse-width-modulated waveforms. Each word pair arrives with a strobe at sixteen times the audio rate. A fast clock, about 1024 times the audio rate, drives a 6-bit counter that forms one slope of a triangular carrier per sample period. Rising slopes and falling slopes take turns, so two consecutive samples set the leading and the trailing edge of one pulse. The output pulse rate is therefore eight times the audio rate, and the pulses are symmetric about the turning point of the triangle.

Each word pair gives three waveforms. The main waveform carries the coarse (MSB) word. Its duty is capped below 70% and a clip flag reports each half-period in which the cap acted, which leaves idle time at the top of each period to resynchronise a free-running fast clock. The other two waveforms carry the fine (LSB) word and its negation. An analog stage downstream adds them to form a three-level signal.

The sequencer has three named states. `PH_IDLE` is the state after reset, with all outputs low. `PH_RISE` is an up-slope half, in which the output goes high once the count reaches the threshold. `PH_FALL` is a down-slope half, in which the output is high until the count reaches the threshold. The transitions are: IDLE→RISE on the first strobe, RISE→FALL on a strobe, and FALL→RISE on a strobe. Reset returns the sequencer to IDLE from any state. Every strobe latches fresh words (uniform sampling) and restarts the counter at zero.

Top module: `tri_pwm_modulator`

## Requirements
- R1: After reset and before the first strobe, `pwm_main`, `pwm_fine_pos`, `pwm_fine_neg` and `msb_clip` are all low.
- R2: The first strobe after reset starts a rising half. Each later strobe switches to the opposite half: rising becomes falling and falling becomes rising.
- R3: A strobe sampled at a clock edge latches both words and sets the count to 0 for the cycle after that edge. With no strobe, the count advances by one on each clock.
- R4: In a rising half, an output is high exactly when count ≥ 64 − u, where u is that output's unsigned level.
- R5: In a falling half, an output is high exactly when count < u. With equal halves of 64 cycles, the two halves together give a pulse that lasts 2u of 128 cycles and is centred on the half boundary.
- R6: A signed two's-complement word s is mapped to u = s + 32, so s = 0 gives u = 32 (50% duty), −32 gives 0 and +31 gives 63.
- R7: The main level is clamped to u = 44 (the largest level whose duty does not exceed 70%). `msb_clip` is high for the whole half in which the latched MSB word had s + 32 > 44, and low otherwise.
- R8: `pwm_fine_pos` uses u = lsb + 32. `pwm_fine_neg` uses u = 32 − lsb. For lsb = −32 the negation saturates to +31, so u = 63.
- R9: If no strobe arrives, the count stops at 63 and all outputs keep the level they had at count 63 until the next strobe.
- R10: Reset asserted during operation returns the block to the R1 state, and the next strobe again starts a rising half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast carrier clock (about 1024× audio rate) |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_stb | input | 1 | One-cycle strobe: latch words, restart the half-period |
| msb_word | input | 6 | Signed coarse word |
| lsb_word | input | 6 | Signed fine word |
| pwm_main | output | 1 | PWM of the clamped coarse word |
| pwm_fine_pos | output | 1 | PWM of the fine word |
| pwm_fine_neg | output | 1 | PWM of the negated fine word |
| msb_clip | output | 1 | High for a half-period whose coarse word was clamped |

## Verification
The assertions assume `smp_stb` is a clean synchronous pulse and that reset is the only other event that can move the sequencer. The edge-monotonicity properties are valid only in that case, because they treat any cycle without a strobe as a continuation of the same slope. The stimulus raises the strobe for exactly one clock, driven at a falling edge. It changes the words only together with the strobe, so every half-period sees a stable latched level. Half lengths of 20, 64 and 80 cycles cover the cases where the count is restarted early, wraps exactly, and saturates.

// File: rtl/tri_pwm_pkg.sv
package tri_pwm_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RISE = 2'd1,
        PH_FALL = 2'd2
    } phase_t;

endpackage

// File: rtl/pwm_sample_cond.sv
module pwm_sample_cond #(
    parameter int W       = 6,
    parameter int CAP_PCT = 70
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] msb_s,
    input  logic [W-1:0] lsb_s,
    output logic [W-1:0] msb_u,
    output logic [W-1:0] lsbp_u,
    output logic [W-1:0] lsbn_u,
    output logic         clip
);

    localparam int           CAP_U = ((2 ** W) * CAP_PCT) / 100;
    localparam logic [W-1:0] CAP_V = W'(CAP_U);
    localparam logic [W-1:0] SMIN  = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] msb_off, lsb_off, neg_s, neg_off;
    logic [W-1:0] msb_lim;
    logic         over;

    // offset binary: flip the sign bit (adds half scale)
    always_comb begin
        msb_off = {~msb_s[W-1], msb_s[W-2:0]};
        lsb_off = {~lsb_s[W-1], lsb_s[W-2:0]};
        neg_s   = (lsb_s == SMIN) ? ~SMIN : (~lsb_s + W'(1));
        neg_off = {~neg_s[W-1], neg_s[W-2:0]};
        over    = (msb_off > CAP_V);
        msb_lim = over ? CAP_V : msb_off;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msb_u  <= '0;
            lsbp_u <= '0;
            lsbn_u <= '0;
            clip   <= 1'b0;
        end else if (load) begin
            msb_u  <= msb_lim;
            lsbp_u <= lsb_off;
            lsbn_u <= neg_off;
            clip   <= over;
        end
    end

    // R7
    main_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msb_u <= CAP_V);

    // R7
    clip_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clip |-> (msb_u == CAP_V));

    // R8
    fine_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && lsb_s != SMIN) |=> ((lsbp_u + lsbn_u) == W'(0)));

endmodule

// File: rtl/pwm_carrier_fsm.sv
module pwm_carrier_fsm
    import tri_pwm_pkg::*;
#(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    output phase_t       phase_q,
    output logic [W-1:0] count_q
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    phase_t       phase_d;
    logic [W-1:0] count_d;

    // next-state selection
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: if (strobe) phase_d = PH_RISE;
            PH_RISE: if (strobe) phase_d = PH_FALL;
            PH_FALL: if (strobe) phase_d = PH_RISE;
            default: phase_d = PH_IDLE;
        endcase
    end

    // carrier slope counter: restart on strobe, saturate at top
    always_comb begin
        if (strobe)
            count_d = '0;
        else if (phase_q == PH_IDLE || count_q == TOP)
            count_d = count_q;
        else
            count_d = count_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            count_q <= '0;
        end else begin
            phase_q <= phase_d;
            count_q <= count_d;
        end
    end

    // R2
    idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE && strobe) |=> (phase_q == PH_RISE));

    // R2
    rise_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RISE && strobe) |=> (phase_q == PH_FALL));

    // R2
    fall_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_FALL && strobe) |=> (phase_q == PH_RISE));

    // R3
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (count_q == '0));

    // R3
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && phase_q != PH_IDLE && count_q != TOP)
            |=> (count_q == $past(count_q) + W'(1)));

    // R9
    saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && count_q == TOP) |=> (count_q == TOP));

endmodule

// File: rtl/pwm_edge_cmp.sv
module pwm_edge_cmp
    import tri_pwm_pkg::*;
#(
    parameter int W = 6
) (
    input  phase_t       phase,
    input  logic [W-1:0] count,
    input  logic [W-1:0] level,
    output logic         pwm
);

    localparam logic [W:0] FULL = {1'b1, {W{1'b0}}};

    logic [W:0] rise_thr;

    always_comb begin
        rise_thr = FULL - {1'b0, level};
        unique case (phase)
            PH_RISE: pwm = ({1'b0, count} >= rise_thr);
            PH_FALL: pwm = (count < level);
            default: pwm = 1'b0;
        endcase
    end

endmodule

// File: rtl/tri_pwm_modulator.sv
module tri_pwm_modulator
    import tri_pwm_pkg::*;
#(
    parameter int W       = 6,
    parameter int CAP_PCT = 70
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_stb,
    input  logic [W-1:0] msb_word,
    input  logic [W-1:0] lsb_word,
    output logic         pwm_main,
    output logic         pwm_fine_pos,
    output logic         pwm_fine_neg,
    output logic         msb_clip
);

    localparam int NCH = 3;

    phase_t       phase;
    logic [W-1:0] count;
    logic [W-1:0] lvl [NCH];
    logic [NCH-1:0] pwm_v;

    pwm_sample_cond #(.W(W), .CAP_PCT(CAP_PCT)) u_cond (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (smp_stb),
        .msb_s  (msb_word),
        .lsb_s  (lsb_word),
        .msb_u  (lvl[0]),
        .lsbp_u (lvl[1]),
        .lsbn_u (lvl[2]),
        .clip   (msb_clip)
    );

    pwm_carrier_fsm #(.W(W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (smp_stb),
        .phase_q (phase),
        .count_q (count)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_cmp
        pwm_edge_cmp #(.W(W)) u_cmp (
            .phase (phase),
            .count (count),
            .level (lvl[g]),
            .pwm   (pwm_v[g])
        );
    end

    assign pwm_main     = pwm_v[0];
    assign pwm_fine_pos = pwm_v[1];
    assign pwm_fine_neg = pwm_v[2];

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> (pwm_v == '0 && !msb_clip));

    // R4
    rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RISE && !smp_stb && pwm_main) |=> pwm_main);

    // R4
    rise_hold_fine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RISE && !smp_stb && pwm_fine_pos) |=> pwm_fine_pos);

    // R5
    fall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FALL && !smp_stb && !pwm_main) |=> !pwm_main);

    // R7
    clip_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> $stable(msb_clip));

endmodule

// File: tb/tb_tri_pwm_modulator.sv
module tb_tri_pwm_modulator;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_stb = 1'b0;
    logic [5:0] msb_word = '0;
    logic [5:0] lsb_word = '0;
    logic       pwm_main, pwm_fine_pos, pwm_fine_neg, msb_clip;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit exp_rise = 1'b1;

    always #5 clk = ~clk;

    tri_pwm_modulator dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .smp_stb      (smp_stb),
        .msb_word     (msb_word),
        .lsb_word     (lsb_word),
        .pwm_main     (pwm_main),
        .pwm_fine_pos (pwm_fine_pos),
        .pwm_fine_neg (pwm_fine_neg),
        .msb_clip     (msb_clip)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // R1 R10: reset, then verify the quiet idle state with no strobe
    task automatic do_reset(input string tag);
        int bad;
        rst_n = 1'b0;
        smp_stb = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        bad = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (pwm_main || pwm_fine_pos || pwm_fine_neg || msb_clip) bad++;
        end
        check(bad == 0, {tag, " idle outputs high count"}, bad, 0);
        exp_rise = 1'b1;
    endtask

    // one half-period of len cycles starting with a strobe
    task automatic do_half(input int m, input int l, input int len, input string tag);
        int um, ul, un, c;
        bit ck;
        int bm, bp, bn, bc, hm, hp, hn, xm, xp, xn;
        bit em, ep, en;
        um = m + 32;
        ck = (um > 44);
        if (ck) um = 44;
        ul = l + 32;
        un = (l == -32) ? 63 : 32 - l;
        msb_word = 6'(m);
        lsb_word = 6'(l);
        smp_stb = 1'b1;
        bm = 0; bp = 0; bn = 0; bc = 0;
        hm = 0; hp = 0; hn = 0; xm = 0; xp = 0; xn = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i == 0) smp_stb = 1'b0;
            c = (i > 63) ? 63 : i;
            em = exp_rise ? (c >= 64 - um) : (c < um);
            ep = exp_rise ? (c >= 64 - ul) : (c < ul);
            en = exp_rise ? (c >= 64 - un) : (c < un);
            if (pwm_main != em) bm++;
            if (pwm_fine_pos != ep) bp++;
            if (pwm_fine_neg != en) bn++;
            if (msb_clip != ck) bc++;
            hm += int'(pwm_main);  xm += int'(em);
            hp += int'(pwm_fine_pos); xp += int'(ep);
            hn += int'(pwm_fine_neg); xn += int'(en);
        end
        check(bm == 0, {tag, " main highs"}, hm, xm);
        check(bp == 0, {tag, " fine_pos highs"}, hp, xp);
        check(bn == 0, {tag, " fine_neg highs"}, hn, xn);
        check(bc == 0, {tag, " clip (R7) mismatched cycles"}, bc, 0);
        exp_rise = !exp_rise;
    endtask

    initial begin
        do_reset("R1 power-up");
        // R2 R4 R6: zero input gives a 50% centred pulse
        do_half(0, 0, 64, "R2 R4 R6 zero rise");
        do_half(0, 0, 64, "R2 R5 R6 zero fall");
        // R7 R8: exactly at cap, max fine word; then clip and min fine word
        do_half(12, 31, 64, "R7 R8 at-cap rise");
        do_half(13, -32, 64, "R7 R8 over-cap fall");
        do_half(31, -1, 64, "R7 R4 full-scale rise");
        do_half(-32, 1, 64, "R6 R5 zero-level fall");
        do_half(-32, -32, 64, "R6 R8 min rise");
        do_half(31, 31, 64, "R7 R8 max fall");
        // R9: late strobe, count saturates and outputs hold
        do_half(-20, 7, 80, "R9 late rise");
        do_half(20, -7, 80, "R9 late fall");
        // R3: early strobe restarts the count
        do_half(3, 3, 20, "R3 short rise");
        do_half(-3, -3, 64, "R3 after-restart fall");
        do_half(5, -9, 64, "R3 next rise");
        // R10: reset in the middle of a half
        do_half(8, 8, 30, "R10 pre-reset fall");
        do_reset("R10 mid-run");
        do_half(0, 5, 64, "R10 R2 restart rise");
        do_half(-5, 0, 64, "R10 R2 restart fall");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule